// File: doc/BRIEF.md
# Free-Running Multi-Resolution Timestamp Source

This block is a read-only timestamp source that software polls in place of a timer interrupt. Four counters run for as long as the chip is out of reset. The first counts clock cycles. The second counts microseconds, driven by a programmable pre-divider on the clock. The third counts milliseconds and the fourth counts seconds, each driven by a divider that takes its input from the stage below it. No counter has a load, clear or stop function. A synchronous power-on reset is the only thing that sets them back to zero.

To build a delay or time an interval, software reads the counter with the resolution it needs and keeps that value as the start. It later reads the same counter again and subtracts the start from the new value with unsigned arithmetic. The result is correct even when the counter has wrapped in between. The coarser counters let long intervals be measured without any wrap at all. The bus side is a simple read port: a read strobe and a byte address go in, and registered data comes back one cycle later.

Top module: `ts_source`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge sets all four counters, all dividers, `rd_data` and `rd_valid` to zero. Nothing else can clear a counter.
- R2: The cycle counter adds one on every rising clock edge out of reset and wraps from 2^CNT_W-1 to 0.
- R3: The microsecond counter adds exactly one once every CLK_MHZ clock cycles. Its first step is on the CLK_MHZ-th edge after reset is released.
- R4: The millisecond counter adds one on every US_PER_MS-th microsecond tick, on the same edge as that microsecond tick.
- R5: The second counter adds one on every MS_PER_S-th millisecond tick, on the same edge as that millisecond tick.
- R6: Reads are decoded by byte offset: 0x0 is cycles, 0x4 is microseconds, 0x8 is milliseconds and 0xC is seconds. The selected counter is zero-extended to 32 bits.
- R7: A read whose offset has a nonzero value in `rd_addr[1:0]` returns zero.
- R8: `rd_data` and `rd_valid` change on the edge after the one that samples `rd_en`. `rd_data` holds the counter value from before that sampling edge. `rd_valid` is high for exactly one cycle per read cycle.
- R9: While `rd_en` is low, `rd_data` keeps its last value.
- R10: For two reads of the same counter, the unsigned difference (later minus earlier) modulo 2^CNT_W equals the number of that counter's ticks between the two reads, including when the counter wrapped in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every counter is timed from it |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| rd_addr | input | 4 | Byte offset of the counter to read |
| rd_data | output | 32 | Registered read data, zero-extended counter value |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries a new read |

## Verification
The bench uses small divide factors and a narrow counter width, so that the tick cascade and a full wrap of the cycle counter both fit in a short run.

Directed reads check the following:
- reads placed exactly on the divider boundaries show whether a tick comes one cycle early or late;
- reads on either side of the cycle counter's wrap, with their difference, show that an unsigned subtraction survives wraparound;
- a reset in the middle of the run shows that every counter restarts at zero.

Random reads at random gaps then cover all four aligned offsets and the misaligned ones, and separate a decode error from a timing error. Idle stretches between reads show that the output holds its last value.

// File: rtl/ts_pkg.sv
// Package: shared constants and the register-select type for the
// timestamp source. Assumes a 32-bit data bus and 16 bytes of space.
package ts_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int NUM_CNT = 4;

    // Counter select, taken from rd_addr[3:2]; order fixes the offsets.
    typedef enum logic [1:0] {
        SEL_CYCLE = 2'd0,
        SEL_USEC  = 2'd1,
        SEL_MSEC  = 2'd2,
        SEL_SEC   = 2'd3
    } cnt_sel_t;
endpackage

// File: rtl/tick_divider.sv
// Module: tick_divider
// Counts input ticks and emits one output tick (combinationally, in the
// same cycle as the input tick) on every DIV-th input tick.
// Assumes DIV >= 1; with DIV == 1 the output follows the input.
module tick_divider #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_tick,
    output logic out_tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TC = CW'(DIV - 1);

    logic [CW-1:0] phase_q;
    logic          at_tc;

    // Terminal-count detect for the current phase.
    always_comb begin
        at_tc    = (phase_q == TC);
        out_tick = in_tick && at_tc;
    end

    // Phase advance on each input tick, returning to zero after TC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (in_tick) begin
            phase_q <= at_tc ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/wrap_counter.sv
// Module: wrap_counter
// Free-running W-bit counter that adds one per step and wraps naturally.
// Assumes step is a single-cycle pulse (or held high for every cycle).
module wrap_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] count
);
    // Count register: cleared only by reset, never loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/reg_read_port.sv
// Module: reg_read_port
// Registered read port: decodes a byte offset into one of NUM_CNT counters
// and returns it zero-extended one cycle later. Misaligned offsets read 0.
// Assumes CNT_W <= DATA_W.
module reg_read_port
    import ts_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   counts,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            rd_valid
);
    cnt_sel_t          sel;
    logic              aligned;
    logic [DATA_W-1:0] rd_next;

    // Offset decode and zero-extension of the selected counter.
    always_comb begin
        sel     = cnt_sel_t'(rd_addr[3:2]);
        aligned = (rd_addr[1:0] == 2'b00);
        rd_next = '0;
        if (aligned) begin
            rd_next[CNT_W-1:0] = counts[sel];
        end
    end

    // Output register: capture on a read, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_next;
            end
        end
    end
endmodule

// File: rtl/ts_source.sv
// Module: ts_source (top)
// Four free-running counters (cycles, microseconds, milliseconds, seconds)
// fed by a cascade of tick dividers, behind a registered read port.
// Assumes CLK_MHZ is the clock frequency in MHz; no write path exists.
module ts_source
    import ts_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int US_PER_MS = 1000,
    parameter int MS_PER_S  = 1000,
    parameter int CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    // Divide factor of the stage feeding counter i (stage 0 is the clock).
    function automatic int stage_div(input int i);
        case (i)
            1:       return CLK_MHZ;
            2:       return US_PER_MS;
            3:       return MS_PER_S;
            default: return 1;
        endcase
    endfunction

    logic [NUM_CNT-1:0]            tick;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

    // Stage 0 ticks on every clock.
    assign tick[0] = 1'b1;

    // Divider cascade: each stage is fed by the tick of the stage below.
    for (genvar g = 1; g < NUM_CNT; g++) begin : g_div
        tick_divider #(
            .DIV (stage_div(g))
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_tick  (tick[g-1]),
            .out_tick (tick[g])
        );
    end

    // One free-running counter per resolution.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        wrap_counter #(
            .W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (tick[g]),
            .count (cnt_q[g])
        );
    end

    reg_read_port #(
        .CNT_W (CNT_W)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .counts   (cnt_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/ts_source_chk.sv
// Module: ts_source_chk
// Property checker for ts_source, attached by bind below.
module ts_source_chk
    import ts_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int CNT_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          rd_en,
    input logic [DATA_W-1:0]             rd_data,
    input logic                          rd_valid,
    input logic [NUM_CNT-1:0]            tick,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);
    logic [31:0] gap_q;

    // Cycles since the last microsecond tick, kept apart from the divider.
    always_ff @(posedge clk) begin
        if (!rst_n || tick[1]) gap_q <= '0;
        else                   gap_q <= gap_q + 1'b1;
    end

    // R1: a reset edge leaves the outputs and counters at zero.
    a_r1_reset_clear: assert property (@(posedge clk)
        !$past(rst_n) |-> (rd_valid == 1'b0 && rd_data == '0 && cnt_q == '0));

    // R2: the cycle counter steps by one on every edge out of reset.
    a_r2_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt_q[0] == CNT_W'($past(cnt_q[0]) + 1'b1));

    // R3: a microsecond tick comes exactly CLK_MHZ cycles after the last.
    a_r3_us_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick[1] |-> gap_q == 32'(CLK_MHZ - 1));

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_step
        // R3: each counter moves by its tick and by nothing else.
        a_r3_step_by_tick: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> cnt_q[g] == CNT_W'($past(cnt_q[g]) + CNT_W'($past(tick[g]))));
    end

    for (genvar g = 2; g < NUM_CNT; g++) begin : g_nest
        // R4, R5: a coarse tick only occurs together with the finer tick.
        a_r4_nested_tick: assert property (@(posedge clk) disable iff (!rst_n)
            tick[g] |-> tick[g-1]);
    end

    // R8: valid follows the read strobe by one cycle.
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rd_valid == $past(rd_en));

    // R9: data holds when no read was sampled.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en)) |-> $stable(rd_data));
endmodule

bind ts_source ts_source_chk #(
    .CLK_MHZ (CLK_MHZ),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .tick     (tick),
    .cnt_q    (cnt_q)
);

// File: tb/test_ts_source.sv
// Bench for ts_source: directed corner reads plus seeded random reads,
// compared against a model computed from the cycle count since reset.
module test_ts_source;
    localparam int CLK_PERIOD = 10;
    localparam int P_MHZ  = 4;
    localparam int P_UPM  = 5;
    localparam int P_MPS  = 3;
    localparam int P_W    = 12;
    localparam longint MOD = 64'd1 << P_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int     checks = 0;
    int     failures = 0;
    bit     done = 1'b0;
    longint cyc = 0;

    ts_source #(
        .CLK_MHZ   (P_MHZ),
        .US_PER_MS (P_UPM),
        .MS_PER_S  (P_MPS),
        .CNT_W     (P_W)
    ) i_ts_source (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Edges seen with reset released since the last reset.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Expected read value after k counting edges.
    function automatic logic [31:0] expect_val(input logic [3:0] a, input longint k);
        longint v;
        if (a[1:0] != 2'b00) return 32'd0;
        case (a[3:2])
            2'd0:    v = k;
            2'd1:    v = k / P_MHZ;
            2'd2:    v = k / (P_MHZ * P_UPM);
            default: v = k / (P_MHZ * P_UPM * P_MPS);
        endcase
        return 32'(v % MOD);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One read; returns the value and the edge count it reflects.
    task automatic do_read(input logic [3:0] a, input string req,
                           output logic [31:0] val, output longint snap);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; snap = cyc;
        @(negedge clk);
        rd_en = 1'b0;
        val = rd_data;
        check(req, val, expect_val(a, snap));
        check("R8 valid", {31'd0, rd_valid}, 32'd1);
    endtask

    task automatic wait_until(input longint target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v0, v1, hold;
        longint s0, s1;
        void'($urandom(32'd2024));

        // R1: outputs zero under reset.
        repeat (5) @(negedge clk);
        check("R1 rd_data reset", rd_data, 32'd0);
        check("R1 rd_valid reset", {31'd0, rd_valid}, 32'd0);
        rst_n = 1'b1;

        // R3: microsecond boundary, read just before and at the first tick.
        do_read(4'h4, "R3 us before first tick", v0, s0);
        wait_until(P_MHZ - 1);
        do_read(4'h4, "R3 us at boundary", v0, s0);
        do_read(4'h4, "R3 us after boundary", v0, s0);

        // R4, R5: millisecond and second boundaries.
        wait_until(P_MHZ * P_UPM - 1);
        do_read(4'h8, "R4 ms at boundary", v0, s0);
        do_read(4'h8, "R4 ms after boundary", v0, s0);
        wait_until(P_MHZ * P_UPM * P_MPS - 1);
        do_read(4'hC, "R5 s at boundary", v0, s0);
        do_read(4'hC, "R5 s after boundary", v0, s0);

        // R7: misaligned offsets.
        do_read(4'h1, "R7 misaligned", v0, s0);
        do_read(4'hE, "R7 misaligned", v0, s0);

        // R9: hold while idle, R8 valid low.
        do_read(4'h0, "R6 cycle", hold, s0);
        repeat (7) @(negedge clk);
        check("R9 hold", rd_data, hold);
        check("R8 valid idle", {31'd0, rd_valid}, 32'd0);

        // R6: random reads over all offsets.
        for (int i = 0; i < 60; i++) begin
            repeat ($urandom_range(0, 40)) @(negedge clk);
            do_read(4'($urandom_range(0, 15)), "R6 random read", v0, s0);
        end

        // R2, R10: wrap of the cycle counter and wrap-safe elapsed time.
        wait_until(MOD - 3);
        do_read(4'h0, "R2 before wrap", v0, s0);
        wait_until(MOD - 1);
        do_read(4'h0, "R2 at wrap", v1, s1);
        do_read(4'h0, "R2 after wrap", v1, s1);
        wait_until(MOD + 50);
        do_read(4'h0, "R10 late read", v1, s1);
        check("R10 elapsed", 32'((v1 - v0) % MOD), 32'((s1 - s0) % MOD));

        // R1: reset in mid-run restarts every counter.
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a += 4) begin
            do_read(4'(a), "R1 after mid-run reset", v0, s0);
        end

        finish_run();
    end
endmodule